// File: doc/BRIEF.md
# Extended-Precision Accumulator ALU

This block is the arithmetic core of a fixed-point signal processor. It holds two 56-bit accumulators, A and B. Each one is built from an 8-bit guard extension, a 24-bit high word and a 24-bit low word. On each clock edge where `op_valid` is high, the block applies one opcode to the selected destination accumulator. The second operand is either a 24-bit source word or the other accumulator. The same edge updates four condition flags: carry, overflow, zero and negative.

The operation set covers four groups:
- add and subtract, each with or without the carry flag;
- fused forms that shift the destination one place before they add or subtract the source;
- one-place arithmetic shifts of the whole accumulator;
- logical shifts, rotates through carry and bitwise operations, all of which act only on the high word.

Compare and magnitude-compare set the flags without writing an accumulator. The accumulators and flags are registered outputs, so the result of an operation is visible on the cycle after its edge.

Top module: `dspalu`

## Requirements
- R1: While `rst_n` is low, both accumulators and all four flags are held at zero.
- R2: When `op_valid` is low, or `op_code` is 22 or above, no accumulator and no flag changes. A valid operation writes only the accumulator that `dst_sel` selects: 0 selects A and 1 selects B.
- R3: With `src_sel`=0, the source is the 24-bit word placed in bits 47:24, with its bit 23 copied into bits 55:48 and zeros in bits 23:0. With `src_sel`=1, the source is the accumulator that is not the destination.
- R4: Opcodes 0 ADD (d+s), 1 ADC (d+s+C), 2 SUB (d-s) and 3 SBC (d-s-C) write the 56-bit result. Flag behaviour:
  - C is the carry out of bit 55 for the add forms and the borrow for the subtract forms.
  - V is set when the exact signed result does not fit in 56 bits.
  - Z and N describe the full 56-bit result.
- R5: Opcode 4 computes 2d+s and opcode 6 computes 2d-s. V covers the whole exact result, shift included. C is the carry or borrow of the 56-bit addition or subtraction that follows the shift.
- R6: Opcode 5 computes floor(d/2)+s and opcode 7 computes floor(d/2)-s. Flags follow the rules of R4.
- R7: Opcode 8 (ASL) doubles d. C takes the old bit 55, and V is set when the old bits 55 and 54 differ. Opcode 9 (ASR) halves d with sign fill, C takes the old bit 0, and V is cleared.
- R8: Opcode 10 (LSL) and opcode 11 (LSR) shift only bits 47:24 by one place with zero fill. C receives the bit shifted out: old bit 47 for LSL, old bit 24 for LSR.
- R9: Opcode 12 (ROL) rotates C and bits 47:24 left as a 25-bit ring, so C takes old bit 47 and bit 24 takes the old C. Opcode 13 (ROR) rotates them right, so C takes old bit 24 and bit 47 takes the old C.
- R10: Opcodes 14 AND, 15 OR, 16 EOR and 17 NOT change only bits 47:24 of the destination. The other operand is the source word, or bits 47:24 of the other accumulator. C is unchanged and V is cleared. For opcodes 10 to 17, Z and N describe bits 47:24 alone.
- R11: Opcode 18 (CMP) sets the flags from d-s and opcode 19 (CMPM) sets them from \|d\|-\|s\|, by the rules of R4. Neither writes an accumulator.
- R12: Opcode 20 (CLR) zeroes the destination, sets Z, clears N and V, and keeps C. Opcode 21 (TFR) copies the source into the destination and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Apply `op_code` on this edge |
| op_code | input | 5 | Operation code (see requirements) |
| dst_sel | input | 1 | Destination: 0 = A, 1 = B |
| src_sel | input | 1 | Source: 0 = `src_word`, 1 = other accumulator |
| src_word | input | 24 | Immediate source word |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| flag_c | output | 1 | Carry / borrow flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The hardest states to reach from the ports are accumulators whose low word and extension hold arbitrary bits, and above all the most negative 56-bit value. The source path can only place a word in the high half of an accumulator, so neither kind of state can be loaded directly. The stimulus builds the most negative value with a short directed sequence: it loads 0x800000 and then applies eight arithmetic left shifts. A magnitude compare against that value must then report overflow. A long pseudo-random stream mixes the right-shifting forms, which move bits down into the low word, with the doubling forms, which move bits up into the extension. A reference model in the bench follows every step of the stream.

// File: rtl/dspalu_pkg.sv
`timescale 1ns/1ps
package dspalu_pkg;
  parameter int EXT_W  = 8;
  parameter int WORD_W = 24;
  localparam int ACC_W  = EXT_W + 2 * WORD_W;
  localparam int WIDE_W = ACC_W + 2;
  localparam int HI_LO  = WORD_W;
  localparam int HI_HI  = 2 * WORD_W - 1;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_ADDL = 5'd4,  OP_ADDR = 5'd5,  OP_SUBL = 5'd6,  OP_SUBR = 5'd7,
    OP_ASL  = 5'd8,  OP_ASR  = 5'd9,  OP_LSL  = 5'd10, OP_LSR  = 5'd11,
    OP_ROL  = 5'd12, OP_ROR  = 5'd13, OP_AND  = 5'd14, OP_OR   = 5'd15,
    OP_EOR  = 5'd16, OP_NOT  = 5'd17, OP_CMP  = 5'd18, OP_CMPM = 5'd19,
    OP_CLR  = 5'd20, OP_TFR  = 5'd21
  } alu_op_e;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } flags_t;

  typedef struct packed {
    acc_t   res;
    flags_t fl;
    logic   wr_acc;
    logic   wr_fl;
  } alu_out_t;

  // Opcodes served by the high-word unit.
  function automatic logic is_word_op(input logic [4:0] op);
    return (op >= OP_LSL) && (op <= OP_NOT);
  endfunction

  // Whole-accumulator arithmetic on a guard-extended exact value.
  function automatic alu_out_t arith_eval(input logic [4:0] op, input acc_t d,
                                          input acc_t s, input flags_t f);
    alu_out_t o;
    logic signed [WIDE_W-1:0] dw, sw, lw, ex;
    logic [ACC_W:0] uc;
    logic sub, cin;
    dw  = {{2{d[ACC_W-1]}}, d};
    sw  = {{2{s[ACC_W-1]}}, s};
    if (op == OP_CMPM) begin
      if (dw[WIDE_W-1]) dw = -dw;
      if (sw[WIDE_W-1]) sw = -sw;
    end
    lw = dw;
    if (op == OP_ADDL || op == OP_SUBL) lw = dw <<< 1;
    if (op == OP_ADDR || op == OP_SUBR) lw = dw >>> 1;
    sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_SUBL) ||
          (op == OP_SUBR) || (op == OP_CMP) || (op == OP_CMPM);
    cin = ((op == OP_ADC) || (op == OP_SBC)) ? f.c : 1'b0;
    if (sub) begin
      ex = lw - sw - {{(WIDE_W-1){1'b0}}, cin};
      uc = {1'b0, lw[ACC_W-1:0]} - {1'b0, sw[ACC_W-1:0]} - {{ACC_W{1'b0}}, cin};
    end else begin
      ex = lw + sw + {{(WIDE_W-1){1'b0}}, cin};
      uc = {1'b0, lw[ACC_W-1:0]} + {1'b0, sw[ACC_W-1:0]} + {{ACC_W{1'b0}}, cin};
    end
    o.res    = ex[ACC_W-1:0];
    o.fl.c   = uc[ACC_W];
    o.fl.v   = !((ex[WIDE_W-1] == ex[WIDE_W-2]) && (ex[WIDE_W-2] == ex[ACC_W-1]));
    o.wr_acc = !((op == OP_CMP) || (op == OP_CMPM));
    o.wr_fl  = 1'b1;
    case (op)
      OP_ASL: begin
        o.res  = {d[ACC_W-2:0], 1'b0};
        o.fl.c = d[ACC_W-1];
        o.fl.v = d[ACC_W-1] ^ d[ACC_W-2];
      end
      OP_ASR: begin
        o.res  = {d[ACC_W-1], d[ACC_W-1:1]};
        o.fl.c = d[0];
        o.fl.v = 1'b0;
      end
      OP_CLR: begin
        o.res  = '0;
        o.fl.c = f.c;
        o.fl.v = 1'b0;
      end
      OP_TFR: begin
        o.res   = s;
        o.wr_fl = 1'b0;
      end
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_ADDL, OP_ADDR, OP_SUBL, OP_SUBR,
      OP_CMP, OP_CMPM: ;
      default: begin
        o.wr_acc = 1'b0;
        o.wr_fl  = 1'b0;
      end
    endcase
    o.fl.z = (o.res == '0);
    o.fl.n = o.res[ACC_W-1];
    return o;
  endfunction

  // High-word operation; returns {new high word, new carry}.
  function automatic logic [WORD_W:0] word_eval(input logic [4:0] op, input word_t h,
                                                input word_t s, input logic cin);
    word_t r;
    logic  c;
    r = h;
    c = cin;
    case (op)
      OP_LSL: begin r = {h[WORD_W-2:0], 1'b0}; c = h[WORD_W-1]; end
      OP_LSR: begin r = {1'b0, h[WORD_W-1:1]}; c = h[0];        end
      OP_ROL: begin r = {h[WORD_W-2:0], cin};  c = h[WORD_W-1]; end
      OP_ROR: begin r = {cin, h[WORD_W-1:1]};  c = h[0];        end
      OP_AND: r = h & s;
      OP_OR:  r = h | s;
      OP_EOR: r = h ^ s;
      OP_NOT: r = ~h;
      default: ;
    endcase
    return {r, c};
  endfunction
endpackage

// File: rtl/dspalu_srcsel.sv
`timescale 1ns/1ps
module dspalu_srcsel
  import dspalu_pkg::*;
(
  input  logic  src_sel,
  input  word_t src_word,
  input  acc_t  oth_acc,
  output acc_t  src_full,
  output word_t src_hi
);
  acc_t imm_full;
  assign imm_full = {{EXT_W{src_word[WORD_W-1]}}, src_word, {WORD_W{1'b0}}};
  assign src_full = src_sel ? oth_acc : imm_full;
  assign src_hi   = src_full[HI_HI:HI_LO];
endmodule

// File: rtl/dspalu_arith.sv
`timescale 1ns/1ps
module dspalu_arith
  import dspalu_pkg::*;
(
  input  logic [4:0] op,
  input  acc_t       dst_acc,
  input  acc_t       src_full,
  input  flags_t     fl_in,
  output alu_out_t   out
);
  assign out = arith_eval(op, dst_acc, src_full, fl_in);
endmodule

// File: rtl/dspalu_word.sv
`timescale 1ns/1ps
module dspalu_word
  import dspalu_pkg::*;
(
  input  logic [4:0] op,
  input  acc_t       dst_acc,
  input  word_t      src_hi,
  input  flags_t     fl_in,
  output alu_out_t   out
);
  logic [WORD_W:0] wres;
  word_t           new_hi;

  assign wres   = word_eval(op, dst_acc[HI_HI:HI_LO], src_hi, fl_in.c);
  assign new_hi = wres[WORD_W:1];

  always_comb begin
    out        = '0;
    out.res    = {dst_acc[ACC_W-1:HI_HI+1], new_hi, dst_acc[HI_LO-1:0]};
    out.fl.c   = wres[0];
    out.fl.v   = 1'b0;
    out.fl.z   = (new_hi == '0);
    out.fl.n   = new_hi[WORD_W-1];
    out.wr_acc = is_word_op(op);
    out.wr_fl  = is_word_op(op);
  end
endmodule

// File: rtl/dspalu.sv
`timescale 1ns/1ps
module dspalu
  import dspalu_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [4:0]              op_code,
  input  logic                    dst_sel,
  input  logic                    src_sel,
  input  logic [WORD_W-1:0]       src_word,
  output logic [ACC_W-1:0]        acc_a,
  output logic [ACC_W-1:0]        acc_b,
  output logic                    flag_c,
  output logic                    flag_v,
  output logic                    flag_z,
  output logic                    flag_n
);
  acc_t     acc_a_q, acc_b_q, dst_acc, oth_acc, src_full;
  word_t    src_hi;
  flags_t   fl_q;
  alu_out_t ar_out, wd_out, sel_out;
  logic     logic_sel, upd_a, upd_b, upd_fl;

  assign dst_acc = dst_sel ? acc_b_q : acc_a_q;
  assign oth_acc = dst_sel ? acc_a_q : acc_b_q;

  dspalu_srcsel u_src (
    .src_sel (src_sel),
    .src_word(src_word),
    .oth_acc (oth_acc),
    .src_full(src_full),
    .src_hi  (src_hi)
  );

  dspalu_arith u_arith (
    .op      (op_code),
    .dst_acc (dst_acc),
    .src_full(src_full),
    .fl_in   (fl_q),
    .out     (ar_out)
  );

  dspalu_word u_word (
    .op     (op_code),
    .dst_acc(dst_acc),
    .src_hi (src_hi),
    .fl_in  (fl_q),
    .out    (wd_out)
  );

  assign logic_sel = is_word_op(op_code);
  assign sel_out   = logic_sel ? wd_out : ar_out;
  assign upd_a     = op_valid && sel_out.wr_acc && !dst_sel;
  assign upd_b     = op_valid && sel_out.wr_acc &&  dst_sel;
  assign upd_fl    = op_valid && sel_out.wr_fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_a_q <= '0;
      acc_b_q <= '0;
      fl_q    <= '0;
    end else begin
      if (upd_a)  acc_a_q <= sel_out.res;
      if (upd_b)  acc_b_q <= sel_out.res;
      if (upd_fl) fl_q    <= sel_out.fl;
    end
  end

  assign acc_a  = acc_a_q;
  assign acc_b  = acc_b_q;
  assign flag_c = fl_q.c;
  assign flag_v = fl_q.v;
  assign flag_z = fl_q.z;
  assign flag_n = fl_q.n;
endmodule

// File: rtl/dspalu_chk.sv
`timescale 1ns/1ps
module dspalu_chk
  import dspalu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [4:0]       op_code,
  input logic             dst_sel,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b,
  input logic             flag_c,
  input logic             flag_v,
  input logic             flag_z,
  input logic             flag_n
);
  logic [3:0] flags;
  logic       word_op, cmp_op;
  assign flags   = {flag_c, flag_v, flag_z, flag_n};
  assign word_op = op_code >= OP_LSL && op_code <= OP_NOT;
  assign cmp_op  = op_code == OP_CMP || op_code == OP_CMPM;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_a) && $stable(acc_b) && $stable(flags)));

  a_r2_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ($past(dst_sel) ? $stable(acc_a) : $stable(acc_b)));

  a_r10_ext_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && word_op && !dst_sel) |=>
      ($stable(acc_a[ACC_W-1:HI_HI+1]) && $stable(acc_a[HI_LO-1:0])));

  a_r10_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= OP_AND && op_code <= OP_NOT) |=> ($stable(flag_c) && !flag_v));

  a_r11_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cmp_op) |=> ($stable(acc_a) && $stable(acc_b)));

  a_r12_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLR && dst_sel) |=>
      (acc_b == '0 && flag_z && !flag_n && !flag_v && $stable(flag_c)));

  a_r7_asr_no_v: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ASR) |=> !flag_v);
endmodule

bind dspalu dspalu_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_valid(op_valid),
  .op_code (op_code),
  .dst_sel (dst_sel),
  .acc_a   (acc_a),
  .acc_b   (acc_b),
  .flag_c  (flag_c),
  .flag_v  (flag_v),
  .flag_z  (flag_z),
  .flag_n  (flag_n)
);

// File: tb/sim_dspalu.sv
`timescale 1ns/1ps
module sim_dspalu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic        dst_sel = 1'b0;
  logic        src_sel = 1'b0;
  logic [23:0] src_word = '0;
  logic [55:0] acc_a, acc_b;
  logic        flag_c, flag_v, flag_z, flag_n;

  int tests = 0;
  int fails = 0;

  longint ma = 0, mb = 0;
  bit     mc = 0, mv = 0, mz = 0, mn = 0;
  logic [31:0] lcg = 32'h1234_5678;

  localparam longint M56  = (longint'(1) <<< 56) - 1;
  localparam longint LIM  = longint'(1) <<< 55;

  always #2.5 clk = ~clk;

  dspalu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_sel(dst_sel), .src_sel(src_sel), .src_word(src_word),
    .acc_a(acc_a), .acc_b(acc_b), .flag_c(flag_c), .flag_v(flag_v),
    .flag_z(flag_z), .flag_n(flag_n)
  );

  function automatic longint wrap56(input longint x);
    logic [63:0] t;
    t = x;
    return longint'({{8{t[55]}}, t[55:0]});
  endfunction

  function automatic string req_of(input int op, input bit vld);
    if (!vld || op > 21) return "R2";
    if (op <= 3)  return "R4";
    if (op == 4 || op == 6) return "R5";
    if (op == 5 || op == 7) return "R6";
    if (op <= 9)  return "R7";
    if (op <= 11) return "R8";
    if (op <= 13) return "R9";
    if (op <= 17) return "R10";
    if (op <= 19) return "R11";
    return "R12";
  endfunction

  function automatic logic [31:0] next_lcg(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  // Reference model of one operation.
  task automatic model_step(input int op, input bit dsel, input bit ssel, input logic [23:0] w);
    longint d, o, s, l, sv, ex, u, r;
    logic [63:0] dv, ov, ub;
    logic [23:0] hi, sh, nh;
    bit nc, cin, sub, wr, wf;
    d  = dsel ? mb : ma;
    o  = dsel ? ma : mb;
    s  = ssel ? o : (longint'($signed(w)) <<< 24);   // R3 source placement
    wr = 1; wf = 1; r = d;
    if (op <= 7 || op == 18 || op == 19) begin
      l  = d; sv = s;
      if (op == 19) begin l = (d < 0) ? -d : d; sv = (s < 0) ? -s : s; end
      if (op == 4 || op == 6) l = d * 2;
      if (op == 5 || op == 7) l = d >>> 1;
      sub = (op == 2 || op == 3 || op == 6 || op == 7 || op == 18 || op == 19);
      cin = (op == 1 || op == 3) ? mc : 0;
      if (sub) begin ex = l - sv - cin; u = (l & M56) - (sv & M56) - cin; end
      else     begin ex = l + sv + cin; u = (l & M56) + (sv & M56) + cin; end
      ub = u;
      r  = wrap56(ex);
      mc = ub[56];
      mv = (ex < -LIM) || (ex >= LIM);
      mz = (r == 0); mn = (r < 0);
      if (op >= 18) wr = 0;
    end else if (op == 8 || op == 9) begin
      dv = d;
      if (op == 8) begin r = wrap56(d * 2); mc = dv[55]; mv = dv[55] ^ dv[54]; end
      else         begin r = d >>> 1;       mc = dv[0];  mv = 0; end
      mz = (r == 0); mn = (r < 0);
    end else if (op >= 10 && op <= 17) begin
      dv = d; ov = o;
      hi = dv[47:24];
      sh = ssel ? ov[47:24] : w;
      nc = mc; nh = hi;
      case (op)
        10: begin nh = hi << 1;          nc = hi[23]; end
        11: begin nh = hi >> 1;          nc = hi[0];  end
        12: begin nh = {hi[22:0], mc};   nc = hi[23]; end
        13: begin nh = {mc, hi[23:1]};   nc = hi[0];  end
        14: nh = hi & sh;
        15: nh = hi | sh;
        16: nh = hi ^ sh;
        default: nh = ~hi;
      endcase
      dv[47:24] = nh;
      r  = wrap56(longint'(dv));
      mc = nc; mv = 0; mz = (nh == 0); mn = nh[23];
    end else if (op == 20) begin
      r = 0; mv = 0; mz = 1; mn = 0;
    end else if (op == 21) begin
      r = s; wf = 0;
    end else begin
      wr = 0; wf = 0;
    end
    if (wr) begin
      if (dsel) mb = r; else ma = r;
    end
  endtask

  task automatic check_all(input string req);
    tests++;
    if (acc_a !== ma[55:0] || acc_b !== mb[55:0] ||
        {flag_c, flag_v, flag_z, flag_n} !== {mc, mv, mz, mn}) begin
      fails++;
      $display("FAIL %s op=%0d: a=%h b=%h cvzn=%b%b%b%b expected a=%h b=%h cvzn=%b%b%b%b",
               req, op_code, acc_a, acc_b, flag_c, flag_v, flag_z, flag_n,
               ma[55:0], mb[55:0], mc, mv, mz, mn);
    end
  endtask

  // Entered at a falling edge; drives, lets one rising edge pass, checks.
  task automatic do_op(input int op, input bit dsel, input bit ssel,
                       input logic [23:0] w, input bit vld);
    op_valid = vld; op_code = op[4:0]; dst_sel = dsel; src_sel = ssel; src_word = w;
    @(negedge clk);
    if (vld) model_step(op, dsel, ssel, w);
    check_all(req_of(op, vld));
    op_valid = 0;
  endtask

  logic [23:0] corner [6] = '{24'h000000, 24'h000001, 24'h7FFFFF,
                              24'h800000, 24'hFFFFFF, 24'h5A3C96};

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held at zero under reset
    tests++;
    if (acc_a !== 0 || acc_b !== 0 || {flag_c, flag_v, flag_z, flag_n} !== 0) begin
      fails++;
      $display("FAIL R1: a=%h b=%h flags=%b expected all zero", acc_a, acc_b,
               {flag_c, flag_v, flag_z, flag_n});
    end
    rst_n = 1;

    // R3: immediate placement with sign extension
    do_op(21, 0, 0, 24'h800000, 1);
    tests++;
    if (acc_a !== 56'hFF_800000_000000) begin
      fails++;
      $display("FAIL R3: a=%h expected ff800000000000", acc_a);
    end
    // R11 corner: build most negative value, then magnitude compare
    for (int i = 0; i < 8; i++) do_op(8, 0, 0, 24'h0, 1);
    tests++;
    if (acc_a !== 56'h80_000000_000000) begin
      fails++;
      $display("FAIL R7: a=%h expected 80000000000000", acc_a);
    end
    do_op(19, 0, 0, 24'h000000, 1);
    tests++;
    if (flag_v !== 1'b1) begin
      fails++;
      $display("FAIL R11: v=%b expected 1", flag_v);
    end
    // R2: idle cycles with active-looking inputs, and undefined codes
    do_op(0, 0, 0, 24'h123456, 0);
    do_op(22, 1, 0, 24'h123456, 1);
    do_op(31, 0, 1, 24'h654321, 1);

    // Ordered sweep over every code, destination, source kind and corner word
    for (int op = 0; op < 23; op++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 6; k++) begin
            do_op(5, d[0], 0, corner[(k + 2) % 6], 1);   // stir low bits
            do_op(op, d[0], s[0], corner[k], 1);
          end

    // Pseudo-random stream
    for (int n = 0; n < 6000; n++) begin
      logic [23:0] w;
      lcg = next_lcg(lcg);
      w = lcg[20] ? corner[lcg[27:25] % 6] : lcg[31:8];
      do_op(int'(lcg[7:3]) % 24, lcg[1], lcg[2], w, lcg[30:28] != 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule